// File: doc/BRIEF.md
# Memory card bring-up sequencer

This block walks a freshly inserted memory card from power-up to the point where it can move data. It runs as a finite-state machine that requests card clocks from a clock unit and issues commands through a simple command port: it presents a command index, a 32-bit argument and the response shape it expects, then waits for the command layer to report either a response or a timeout.

The sequence first sets the slow identification clock. It then resets the card and checks the interface-condition echo. Next it polls the operating-conditions application command, with a programmable pause between attempts. After that it reads the identity, obtains and stores the relative card address, reads the card-specific data and raises the clock to the operating rate. It then selects the card, fixes the block length on standard-capacity cards only, and switches the bus to four bits. The result is either a ready flag with the relative address and the capacity-class bit, or a two-bit error code. Both results hold until the next start pulse.

Top module: `card_init_seq`

## Requirements
- R1: After reset and until `start` is pulsed, `card_ready`, `err_valid`, `err_code`, `cmd_valid` and `clk_req` are all 0; `card_ready` and `err_valid` are never 1 together.
- R2: On `start` the block first raises `clk_req` with `clk_rate`=1 (identification rate) and holds it until `clk_ack`. Only then does it issue index 0 with argument 0 and response shape 0 (none). Response shapes are 0 none, 1 short, 2 long, 3 short with busy. A command stays unchanged on the port until `rsp_done` or `rsp_timeout`.
- R3: The next command is index 8 with argument 0x1AA and shape 1. A timeout on it ends the sequence with `err_code`=1 (unsupported).
- R4: If the index 8 response word is not exactly 0x000001AA, the sequence ends with `err_code`=2 (unusable).
- R5: Each polling attempt is index 55 with argument 0, then index 41 with argument 0x50FF8000, both with shape 1. If the index 41 response lacks any bit of 0x00FF8000, the sequence ends with `err_code`=2.
- R6: Attempts repeat while bit 31 of the index 41 response is 0. If the attempt numbered MAX_TRIES (default 1000) is still not ready, the sequence ends with `err_code`=3. If that attempt is ready, the sequence goes on.
- R7: After a not-ready response, `cmd_valid` stays low for exactly `retry_gap`+1 cycles before the next index 55.
- R8: After readiness come index 2 (argument 0, shape 2), then index 3 (argument 0, shape 1), whose response bits 31:16 become the relative address. Index 9 follows with argument {address,16'h0} and shape 2.
- R9: The block then requests `clk_rate`=3 (fast rate) if `hs_capable` is 1, or 2 otherwise, and waits for `clk_ack`. It then issues index 7 with argument {address,16'h0} and shape 3.
- R10: Index 16 with argument 512 and shape 1 is issued only when bit 30 of the accepted index 41 response was 0. `card_ccs` reports that bit.
- R11: Last come index 55 with argument {address,16'h0}, then index 6 with argument 2, both shape 1. Then `card_ready`=1 and `card_rca` holds the address.
- R12: A timeout on any command other than index 8 ends the sequence with `err_code`=3, and no further command is issued.
- R13: The ready or error result holds until the next `start`. The cycle after `start` clears both and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) the bring-up sequence |
| hs_capable | input | 1 | Host supports the fast operating rate |
| retry_gap | input | GAP_W | Idle cycles (minus one) between polling attempts |
| clk_req | output | 1 | Clock change requested |
| clk_rate | output | 2 | Requested rate: 1 identification, 2 normal, 3 fast |
| clk_ack | input | 1 | Clock unit reports the requested rate is stable |
| cmd_valid | output | 1 | Command presented to the command layer |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp | output | 2 | Expected response shape |
| rsp_done | input | 1 | Response received for the presented command |
| rsp_timeout | input | 1 | Presented command got no response |
| rsp_word | input | 32 | First response word |
| card_ready | output | 1 | Card has reached the transfer-ready state |
| card_rca | output | 16 | Relative card address |
| card_ccs | output | 1 | Capacity-class bit from the operating conditions |
| err_valid | output | 1 | Sequence ended with an error |
| err_code | output | 2 | 0 none, 1 unsupported, 2 unusable, 3 I/O error |

## Verification
The hardest state to reach is the retry limit. It needs a card that answers "not ready" a thousand times and then either stays busy or becomes ready on the very last allowed attempt. The bench's responder model is driven from a scripted list of card answers, so it produces both runs with the full default count and a zero pause. The pause length is checked separately, with a nonzero gap, by measuring how many idle cycles pass between a not-ready answer and the next attempt.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_CLK_ID, ST_RESET, ST_IFCOND, ST_APP_A, ST_OPCOND, ST_GAP,
    ST_IDENT, ST_ADDR, ST_CSD, ST_CLK_OP, ST_SELECT, ST_BLKLEN, ST_APP_B,
    ST_BUSW, ST_READY, ST_FAIL
  } step_t;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SHORT = 2'd1,
    RSP_LONG  = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_kind_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_UNSUP    = 2'd1,
    ERR_UNUSABLE = 2'd2,
    ERR_IO       = 2'd3
  } err_t;

  localparam logic [31:0] IFCOND_ARG = 32'h0000_01AA;
  localparam logic [31:0] OPCOND_ARG = 32'h50FF_8000;
  localparam logic [31:0] VOLT_MASK  = 32'h00FF_8000;
  localparam logic [31:0] BLKLEN_ARG = 32'd512;
  localparam logic [31:0] BUSW_ARG   = 32'd2;

  localparam logic [1:0] RATE_ID   = 2'd1;
  localparam logic [1:0] RATE_NORM = 2'd2;
  localparam logic [1:0] RATE_FAST = 2'd3;

  typedef struct packed {
    logic        valid;
    logic [5:0]  idx;
    logic [31:0] arg;
    rsp_kind_t   kind;
  } cmd_t;
endpackage

// File: rtl/cis_cmd_table.sv
module cis_cmd_table
  import cis_pkg::*;
#(
  parameter int RCA_W = 16
) (
  input  step_t             step,
  input  logic [RCA_W-1:0]  rca,
  output cmd_t              cmd
);
  localparam int PAD_W = 32 - RCA_W;
  logic [31:0] rca_arg;

  assign rca_arg = {rca, {PAD_W{1'b0}}};

  always_comb begin
    cmd = '{valid: 1'b0, idx: 6'd0, arg: 32'd0, kind: RSP_NONE};
    case (step)
      ST_RESET:  cmd = '{valid: 1'b1, idx: 6'd0,  arg: 32'd0,      kind: RSP_NONE};
      ST_IFCOND: cmd = '{valid: 1'b1, idx: 6'd8,  arg: IFCOND_ARG, kind: RSP_SHORT};
      ST_APP_A:  cmd = '{valid: 1'b1, idx: 6'd55, arg: 32'd0,      kind: RSP_SHORT};
      ST_OPCOND: cmd = '{valid: 1'b1, idx: 6'd41, arg: OPCOND_ARG, kind: RSP_SHORT};
      ST_IDENT:  cmd = '{valid: 1'b1, idx: 6'd2,  arg: 32'd0,      kind: RSP_LONG};
      ST_ADDR:   cmd = '{valid: 1'b1, idx: 6'd3,  arg: 32'd0,      kind: RSP_SHORT};
      ST_CSD:    cmd = '{valid: 1'b1, idx: 6'd9,  arg: rca_arg,    kind: RSP_LONG};
      ST_SELECT: cmd = '{valid: 1'b1, idx: 6'd7,  arg: rca_arg,    kind: RSP_BUSY};
      ST_BLKLEN: cmd = '{valid: 1'b1, idx: 6'd16, arg: BLKLEN_ARG, kind: RSP_SHORT};
      ST_APP_B:  cmd = '{valid: 1'b1, idx: 6'd55, arg: rca_arg,    kind: RSP_SHORT};
      ST_BUSW:   cmd = '{valid: 1'b1, idx: 6'd6,  arg: BUSW_ARG,   kind: RSP_SHORT};
      default:   cmd = '{valid: 1'b0, idx: 6'd0,  arg: 32'd0,      kind: RSP_NONE};
    endcase
  end
endmodule

// File: rtl/cis_retry_unit.sv
module cis_retry_unit #(
  parameter int MAX_TRIES = 1000,
  parameter int GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bump,
  input  logic [GAP_W-1:0] gap_val,
  input  logic             gap_run,
  output logic             last_try,
  output logic             gap_done
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRIES - 1);

  logic [CNT_W-1:0] tries_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || clr) tries_q <= '0;
    else if (bump)  tries_q <= tries_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                        gap_q <= '0;
    else if (bump)                  gap_q <= gap_val;
    else if (gap_run && gap_q != 0) gap_q <= gap_q - 1'b1;
  end

  assign last_try = (tries_q == LAST);
  assign gap_done = (gap_q == '0);
endmodule

// File: rtl/card_init_seq.sv
module card_init_seq
  import cis_pkg::*;
#(
  parameter int MAX_TRIES = 1000,
  parameter int GAP_W     = 16,
  parameter int RCA_W     = 16,
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             hs_capable,
  input  logic [GAP_W-1:0] retry_gap,
  output logic             clk_req,
  output logic [1:0]       clk_rate,
  input  logic             clk_ack,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_index,
  output logic [ARG_W-1:0] cmd_arg,
  output logic [1:0]       cmd_rsp,
  input  logic             rsp_done,
  input  logic             rsp_timeout,
  input  logic [ARG_W-1:0] rsp_word,
  output logic             card_ready,
  output logic [RCA_W-1:0] card_rca,
  output logic             card_ccs,
  output logic             err_valid,
  output logic [1:0]       err_code
);
  localparam int RCA_LO = ARG_W - RCA_W;

  step_t            state_q, state_n;
  err_t             err_q, err_n;
  logic [RCA_W-1:0] rca_q;
  logic             ccs_q;
  logic             set_err, ld_rca, ld_ccs, clr_try, bump_try;
  logic             last_try, gap_done;
  cmd_t             cmd;
  logic             vmask_ok;

  cis_cmd_table #(.RCA_W(RCA_W)) u_tbl (
    .step (state_q),
    .rca  (rca_q),
    .cmd  (cmd)
  );

  cis_retry_unit #(.MAX_TRIES(MAX_TRIES), .GAP_W(GAP_W)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_try),
    .bump     (bump_try),
    .gap_val  (retry_gap),
    .gap_run  (state_q == ST_GAP),
    .last_try (last_try),
    .gap_done (gap_done)
  );

  assign vmask_ok = ((rsp_word & VOLT_MASK) == VOLT_MASK);

  always_comb begin
    state_n  = state_q;
    err_n    = ERR_NONE;
    set_err  = 1'b0;
    ld_rca   = 1'b0;
    ld_ccs   = 1'b0;
    clr_try  = 1'b0;
    bump_try = 1'b0;
    if (cmd.valid && rsp_timeout && state_q != ST_IFCOND) begin
      state_n = ST_FAIL;
      set_err = 1'b1;
      err_n   = ERR_IO;
    end else begin
      case (state_q)
        ST_IDLE, ST_READY, ST_FAIL:
          if (start) begin
            state_n = ST_CLK_ID;
            clr_try = 1'b1;
          end
        ST_CLK_ID: if (clk_ack) state_n = ST_RESET;
        ST_RESET:  if (rsp_done) state_n = ST_IFCOND;
        ST_IFCOND:
          if (rsp_timeout) begin
            state_n = ST_FAIL;
            set_err = 1'b1;
            err_n   = ERR_UNSUP;
          end else if (rsp_done) begin
            if (rsp_word == IFCOND_ARG) state_n = ST_APP_A;
            else begin
              state_n = ST_FAIL;
              set_err = 1'b1;
              err_n   = ERR_UNUSABLE;
            end
          end
        ST_APP_A: if (rsp_done) state_n = ST_OPCOND;
        ST_OPCOND:
          if (rsp_done) begin
            if (!vmask_ok) begin
              state_n = ST_FAIL;
              set_err = 1'b1;
              err_n   = ERR_UNUSABLE;
            end else if (rsp_word[31]) begin
              state_n = ST_IDENT;
              ld_ccs  = 1'b1;
            end else if (last_try) begin
              state_n = ST_FAIL;
              set_err = 1'b1;
              err_n   = ERR_IO;
            end else begin
              state_n  = ST_GAP;
              bump_try = 1'b1;
            end
          end
        ST_GAP:    if (gap_done) state_n = ST_APP_A;
        ST_IDENT:  if (rsp_done) state_n = ST_ADDR;
        ST_ADDR:
          if (rsp_done) begin
            state_n = ST_CSD;
            ld_rca  = 1'b1;
          end
        ST_CSD:    if (rsp_done) state_n = ST_CLK_OP;
        ST_CLK_OP: if (clk_ack) state_n = ST_SELECT;
        ST_SELECT: if (rsp_done) state_n = ccs_q ? ST_APP_B : ST_BLKLEN;
        ST_BLKLEN: if (rsp_done) state_n = ST_APP_B;
        ST_APP_B:  if (rsp_done) state_n = ST_BUSW;
        ST_BUSW:   if (rsp_done) state_n = ST_READY;
        default:   state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      rca_q   <= '0;
      ccs_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (clr_try) begin
        err_q <= ERR_NONE;
        rca_q <= '0;
        ccs_q <= 1'b0;
      end
      if (set_err) err_q <= err_n;
      if (ld_rca)  rca_q <= rsp_word[ARG_W-1:RCA_LO];
      if (ld_ccs)  ccs_q <= rsp_word[30];
    end
  end

  assign cmd_valid  = cmd.valid;
  assign cmd_index  = IDX_W'(cmd.idx);
  assign cmd_arg    = ARG_W'(cmd.arg);
  assign cmd_rsp    = cmd.kind;
  assign clk_req    = (state_q == ST_CLK_ID) || (state_q == ST_CLK_OP);
  assign clk_rate   = (state_q == ST_CLK_ID) ? RATE_ID :
                      (state_q == ST_CLK_OP) ? (hs_capable ? RATE_FAST : RATE_NORM) : 2'd0;
  assign card_ready = (state_q == ST_READY);
  assign err_valid  = (state_q == ST_FAIL);
  assign err_code   = err_q;
  assign card_rca   = rca_q;
  assign card_ccs   = ccs_q;
endmodule

// File: rtl/cis_chk.sv
module cis_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        rsp_done,
  input logic        rsp_timeout,
  input logic        clk_req,
  input logic        card_ready,
  input logic        err_valid,
  input logic [1:0]  err_code,
  input logic        card_ccs
);
  // R1
  excl_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(card_ready && err_valid));

  // R2
  excl_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && clk_req));

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !rsp_done && !rsp_timeout) |=>
      (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

  // R3
  ifcond_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == 6'd8 && rsp_timeout) |=>
      (err_valid && err_code == 2'd1));

  // R12
  io_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index != 6'd8 && rsp_timeout) |=>
      (err_valid && err_code == 2'd3 && !cmd_valid));

  // R10
  blklen_std_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == 6'd16) |-> !card_ccs);
endmodule

bind card_init_seq cis_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_index   (cmd_index),
  .cmd_arg     (cmd_arg),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .clk_req     (clk_req),
  .card_ready  (card_ready),
  .err_valid   (err_valid),
  .err_code    (err_code),
  .card_ccs    (card_ccs)
);

// File: tb/sim_card_init_seq.sv
`timescale 1ns/1ps
module sim_card_init_seq;
  localparam int GAP_W = 16;
  localparam int LAT   = 2;
  localparam int WD    = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             hs_capable = 1'b0;
  logic [GAP_W-1:0] retry_gap = '0;
  logic             clk_req;
  logic [1:0]       clk_rate;
  logic             clk_ack = 1'b0;
  logic             cmd_valid;
  logic [5:0]       cmd_index;
  logic [31:0]      cmd_arg;
  logic [1:0]       cmd_rsp;
  logic             rsp_done = 1'b0;
  logic             rsp_timeout = 1'b0;
  logic [31:0]      rsp_word = '0;
  logic             card_ready;
  logic [15:0]      card_rca;
  logic             card_ccs;
  logic             err_valid;
  logic [1:0]       err_code;

  always #2 clk = ~clk;

  card_init_seq u0 (
    .clk(clk), .rst(rst), .start(start), .hs_capable(hs_capable),
    .retry_gap(retry_gap), .clk_req(clk_req), .clk_rate(clk_rate),
    .clk_ack(clk_ack), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_rsp(cmd_rsp), .rsp_done(rsp_done),
    .rsp_timeout(rsp_timeout), .rsp_word(rsp_word), .card_ready(card_ready),
    .card_rca(card_rca), .card_ccs(card_ccs), .err_valid(err_valid),
    .err_code(err_code)
  );

  typedef struct {
    int          is_clk;
    int          idx;
    logic [31:0] arg;
    int          rk;
    int          tmo;
    logic [31:0] word;
  } ev_t;

  ev_t q[$];
  int  checks = 0, failures = 0, cyc = 0;
  bit  wd_hit = 0;
  bit  outstanding = 0;
  int  wait_cnt = 0;
  bit  pend = 0, pend_ready = 0;
  int  pend_err = 0;
  bit  exp_ready = 0;
  int  exp_err = 0;
  bit  fin_ready;
  int  fin_err;
  logic [15:0] fin_rca;
  bit  fin_ccs;
  bit  do_start = 0;
  bit  gap_arm = 0;
  int  gap_mark = 0;

  function automatic string req_of(ev_t e);
    if (e.is_clk) return (e.idx == 1) ? "R2" : "R9";
    case (e.idx)
      0: return "R2";
      8: return "R3";
      55, 41: return "R5";
      2, 3, 9: return "R8";
      7: return "R9";
      16: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic push_cmd(int idx, logic [31:0] arg, int rk, int tmo, logic [31:0] word);
    ev_t e;
    e.is_clk = 0; e.idx = idx; e.arg = arg; e.rk = rk; e.tmo = tmo; e.word = word;
    q.push_back(e);
  endtask

  task automatic push_clk(int rate);
    ev_t e;
    e.is_clk = 1; e.idx = rate; e.arg = '0; e.rk = 0; e.tmo = 0; e.word = '0;
    q.push_back(e);
  endtask

  // fault: 0 none, 1 CMD8 silent, 2 bad echo, 3 voltage mask, 4 CMD2 silent, 5 exhaust
  task automatic build(bit hs, bit ccs, int nbusy, logic [15:0] rca, int fault);
    q.delete();
    fin_ready = 0; fin_err = 0; fin_rca = rca; fin_ccs = ccs;
    push_clk(1);
    push_cmd(0, 32'd0, 0, 0, 32'd0);
    if (fault == 1) begin push_cmd(8, 32'h1AA, 1, 1, 32'd0); fin_err = 1; return; end
    if (fault == 2) begin push_cmd(8, 32'h1AA, 1, 0, 32'h1AB); fin_err = 2; return; end
    push_cmd(8, 32'h1AA, 1, 0, 32'h1AA);
    for (int r = 0; r < nbusy; r++) begin
      push_cmd(55, 32'd0, 1, 0, 32'h120);
      push_cmd(41, 32'h50FF8000, 1, 0, 32'h00FF8000);
    end
    if (fault == 5) begin fin_err = 3; return; end
    push_cmd(55, 32'd0, 1, 0, 32'h120);
    if (fault == 3) begin
      push_cmd(41, 32'h50FF8000, 1, 0, 32'h80FF0000); fin_err = 2; return;
    end
    push_cmd(41, 32'h50FF8000, 1, 0, 32'h80FF8000 | (32'(ccs) << 30));
    if (fault == 4) begin push_cmd(2, 32'd0, 2, 1, 32'd0); fin_err = 3; return; end
    push_cmd(2, 32'd0, 2, 0, 32'h1234);
    push_cmd(3, 32'd0, 1, 0, {rca, 16'h0500});
    push_cmd(9, {rca, 16'h0}, 2, 0, 32'h5555);
    push_clk(hs ? 3 : 2);
    push_cmd(7, {rca, 16'h0}, 3, 0, 32'h900);
    if (!ccs) push_cmd(16, 32'd512, 1, 0, 32'h900);
    push_cmd(55, {rca, 16'h0}, 1, 0, 32'h920);
    push_cmd(6, 32'd2, 1, 0, 32'h920);
    fin_ready = 1;
  endtask

  task automatic step();
    ev_t h;
    @(negedge clk);
    cyc++;
    if (cyc > WD && !wd_hit) begin
      wd_hit = 1;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    if (pend) begin exp_ready = pend_ready; exp_err = pend_err; pend = 0; end
    chk(card_ready == exp_ready, "R13", "card_ready", card_ready, exp_ready);
    chk(err_valid == (exp_err != 0), "R13", "err_valid", err_valid, exp_err != 0);
    chk(err_code == exp_err[1:0], "R13", "err_code", err_code, exp_err);
    rsp_done = 0; rsp_timeout = 0; clk_ack = 0; start = 0;
    if (do_start) begin
      start = 1; do_start = 0; pend = 1; pend_ready = 0; pend_err = 0;
      gap_arm = 0;
    end else if (outstanding) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        h = q.pop_front();
        if (h.is_clk) clk_ack = 1;
        else if (h.tmo != 0) rsp_timeout = 1;
        else begin rsp_done = 1; rsp_word = h.word; end
        if (!h.is_clk && h.idx == 41 && h.tmo == 0 && !h.word[31] &&
            (h.word & 32'h00FF8000) == 32'h00FF8000) begin
          gap_arm = 1; gap_mark = cyc;
        end
        outstanding = 0;
        if (q.size() == 0) begin pend = 1; pend_ready = fin_ready; pend_err = fin_err; end
      end
    end else if (cmd_valid || clk_req) begin
      if (q.size() == 0) begin
        chk(0, "R12", "unexpected request", {cmd_valid, cmd_index}, 0);
      end else begin
        h = q[0];
        if (h.is_clk) begin
          chk(clk_req && !cmd_valid, req_of(h), "clock request", clk_req, 1);
          chk(clk_rate == h.idx[1:0], req_of(h), "clk_rate", clk_rate, h.idx);
        end else begin
          chk(cmd_valid && !clk_req, req_of(h), "command request", cmd_valid, 1);
          chk(cmd_index == h.idx[5:0], req_of(h), "cmd_index", cmd_index, h.idx);
          chk(cmd_arg == h.arg, req_of(h), "cmd_arg", cmd_arg, h.arg);
          chk(cmd_rsp == h.rk[1:0], req_of(h), "cmd_rsp", cmd_rsp, h.rk);
          if (gap_arm) begin
            // R7: idle span before the next attempt
            chk(cyc - gap_mark == int'(retry_gap) + 2, "R7", "retry spacing",
                cyc - gap_mark, int'(retry_gap) + 2);
            gap_arm = 0;
          end
        end
        outstanding = 1; wait_cnt = LAT;
      end
    end
  endtask

  task automatic run(bit hs, bit ccs, int nbusy, logic [15:0] rca, int fault, int gap);
    if (wd_hit) return;
    build(hs, ccs, nbusy, rca, fault);
    hs_capable = hs;
    retry_gap = GAP_W'(gap);
    do_start = 1;
    step();
    while (!(q.size() == 0 && !outstanding && !pend) && !wd_hit) step();
    for (int i = 0; i < 4; i++) step();
    if (fin_ready) begin
      chk(card_rca == fin_rca, "R11", "card_rca", card_rca, fin_rca);
      chk(card_ccs == fin_ccs, "R10", "card_ccs", card_ccs, fin_ccs);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: idle after reset, nothing issued without start
    for (int i = 0; i < 6; i++) begin
      step();
      chk(!cmd_valid && !clk_req, "R1", "idle request", {cmd_valid, clk_req}, 0);
    end
    run(1, 1, 2, 16'h1234, 0, 3);   // R7 R8 R9 R11: fast clock, high capacity
    run(0, 0, 1, 16'hBEEF, 0, 0);   // R9 R10: normal clock, block length sent
    run(1, 0, 0, 16'h0001, 1, 0);   // R3
    run(1, 0, 0, 16'h0001, 2, 0);   // R4
    run(1, 0, 1, 16'h0001, 3, 0);   // R5
    run(1, 0, 0, 16'h0001, 4, 0);   // R12
    run(0, 1, 999, 16'h4321, 0, 0); // R6: ready on the last allowed attempt
    run(1, 0, 1000, 16'h0001, 5, 0); // R6: attempts exhausted
    run(1, 1, 0, 16'hA5A5, 0, 5);   // R13: restart after an error
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule